// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block tracks the coherence state of every line of one processor's write-back data cache on a single shared bus. Each line is Invalid, Shared, Exclusive or Modified. A processor access that hits with enough permission finishes at once. Any other access stalls the processor and raises a bus transaction: a read, a read-for-ownership, an upgrade that carries no data, or a write-back of a dirty victim. When the transaction ends, the same access is looked up again and now finishes as a hit. The cache is direct-mapped, and each tag names a whole coherence block.

Transactions that other caches put on the bus are checked against a second, duplicate copy of the tags. A snoop therefore never takes the processor's tag port. A snoop that hits reports that this cache shares the block, asks for a write-back when it finds the line dirty and the other cache wants the data, and lowers or clears the line state. The protocol is write-invalidate. A write hit on an Exclusive line becomes Modified without any bus traffic.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `bus_req` is low and `cpu_ready` is low.
- R2: A read miss issues command 1 (read) at the access address. The line fills as Exclusive (state code 2) if `bus_shared_in` is low in the completion cycle, and as Shared (code 1) otherwise.
- R3: A write miss issues command 2 (read-for-ownership) at the access address and fills the line as Modified (code 3).
- R4: A write hit on a Shared line issues command 3 (upgrade) at the access address and then moves the line to Modified.
- R5: A write hit on an Exclusive or Modified line completes with no bus transaction and leaves the line Modified.
- R6: A read hit on any valid line completes with no bus transaction and does not change the line state.
- R7: A snoop with command 1 that hits a valid line asserts `snp_wb_req` if the line is Modified, and leaves the line Shared.
- R8: A snoop with command 2 or 3 that hits invalidates the line. With command 2 on a Modified line it also asserts `snp_wb_req`.
- R9: `snp_shared_out` is high exactly when a snoop's address matches a valid line. A snoop with command 4 (write-back) never changes the line state.
- R10: A miss whose target line holds a Modified block with another tag first issues command 4 at that victim's address, then issues the fill.
- R11: From the cycle a miss or upgrade is detected until its `bus_done`, `bus_req` stays high, command and address stay steady, and `cpu_ready` stays low. Bus command 0 means idle. The line index is the low `IDX_W` address bits.
- R12: A processor hit is held off for any cycle in which a snoop targets the same line index.
- R13: A snoop on a different line index is answered in the same cycle as a processor hit. The two lookups do not interfere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Block address of the access |
| cpu_ready | output | 1 | Access completes in this cycle |
| bus_req | output | 1 | Own bus transaction pending |
| bus_cmd | output | 3 | Own bus command (0 idle, 1 read, 2 read-for-ownership, 3 upgrade, 4 write-back) |
| bus_addr | output | ADDR_W | Own bus transaction block address |
| bus_gnt | input | 1 | Bus granted to this controller |
| bus_done | input | 1 | Own transaction completes |
| bus_shared_in | input | 1 | Another cache holds the block, valid with bus_done |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 3 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_shared_out | output | 1 | This cache holds the snooped block |
| snp_wb_req | output | 1 | Dirty block must be written back before memory answers |

## Verification
The assertions check on every cycle that a pending request keeps its command and address until completion, that the processor is never released while its own transaction is pending, that a write-back request always comes with a shared response, that a silent Exclusive-to-Modified upgrade raises no bus request, and that a processor hit is held off when a snoop targets the same index. The resulting line states, the choice between Exclusive and Shared on a fill, the victim write-back order and each snoop's effect on later accesses can only be shown by the bench's access and snoop sequences, which it compares against a model of the line states.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_E = 2'd2, LN_M = 2'd3} line_st_t;
  typedef enum logic [2:0] {BC_NONE = 3'd0, BC_RD = 3'd1, BC_RDX = 3'd2,
                            BC_UPG = 3'd3, BC_WB = 3'd4} bus_cmd_t;

  // state of a valid line after another cache's transaction
  function automatic line_st_t snoop_next(line_st_t s, logic [2:0] c);
    case (c)
      BC_RD:          snoop_next = (s == LN_M || s == LN_E) ? LN_S : s;
      BC_RDX, BC_UPG: snoop_next = LN_I;
      default:        snoop_next = s;
    endcase
  endfunction

  // state installed at the end of an own fill
  function automatic line_st_t fill_state(logic own, logic shared_seen);
    if (own)              fill_state = LN_M;
    else if (shared_seen) fill_state = LN_S;
    else                  fill_state = LN_E;
  endfunction
endpackage

// File: rtl/coh_tag_store.sv
module coh_tag_store #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  localparam int NLINES = 1 << IDX_W;
  logic [TAG_W-1:0] tags [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) tags[i] <= '0;
    end else if (wr_en) begin
      tags[wr_idx] <= wr_tag;
    end
  end

  assign rd_tag = tags[rd_idx];
endmodule

// File: rtl/coh_state_array.sv
module coh_state_array #(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loc_we,
  input  logic [IDX_W-1:0] loc_idx,
  input  logic [1:0]       loc_st,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [1:0]       snp_st,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [1:0]       rd_st_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [1:0]       rd_st_b
);
  localparam int NLINES = 1 << IDX_W;
  logic [1:0] st [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   st[g] <= 2'd0;
      else if (loc_we && loc_idx == IDX_W'(g))      st[g] <= loc_st;
      else if (snp_we && snp_idx == IDX_W'(g))      st[g] <= snp_st;
    end
  end

  assign rd_st_a = st[rd_idx_a];
  assign rd_st_b = st[rd_idx_b];
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import coh_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              bus_req,
  output logic [2:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [2:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared_out,
  output logic              snp_wb_req
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {PH_IDLE, PH_ARB, PH_XFER} phase_t;
  phase_t   ph;
  bus_cmd_t cur_cmd, next_cmd;

  // processor side lookup
  logic [IDX_W-1:0] c_idx;
  logic [TAG_W-1:0] c_tag, p_tag;
  logic [1:0]       c_st_raw;
  line_st_t         c_st;
  logic             c_hit, snp_same_idx, lookup_ok, hit_done, need_bus;

  // snoop side lookup
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag, d_tag;
  logic [1:0]       s_st_raw;
  line_st_t         s_st;
  logic             s_hit, snp_upd;

  // named internal events
  logic     ev_silent_upg, xfer_end, fill_end, loc_we;
  line_st_t loc_st, snp_st_new;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign c_st  = line_st_t'(c_st_raw);
  assign s_st  = line_st_t'(s_st_raw);

  assign c_hit        = (c_st != LN_I) && (p_tag == c_tag);
  assign snp_same_idx = snp_valid && (s_idx == c_idx);
  assign lookup_ok    = (ph == PH_IDLE) && cpu_req && !snp_same_idx;
  assign hit_done     = lookup_ok && c_hit &&
                        (!cpu_we || c_st == LN_E || c_st == LN_M);
  assign need_bus     = lookup_ok && !hit_done;
  assign cpu_ready    = hit_done;

  always_comb begin
    if (c_hit)              next_cmd = BC_UPG;
    else if (c_st == LN_M)  next_cmd = BC_WB;
    else if (cpu_we)        next_cmd = BC_RDX;
    else                    next_cmd = BC_RD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cur_cmd <= BC_NONE;
    end else begin
      case (ph)
        PH_IDLE: if (need_bus) begin
          ph      <= PH_ARB;
          cur_cmd <= next_cmd;
        end
        PH_ARB:  if (bus_gnt)  ph <= PH_XFER;
        PH_XFER: if (bus_done) begin
          ph      <= PH_IDLE;
          cur_cmd <= BC_NONE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign bus_req  = (ph != PH_IDLE);
  assign bus_cmd  = bus_req ? cur_cmd : BC_NONE;
  assign bus_addr = (bus_req && cur_cmd == BC_WB) ? {p_tag, c_idx} : cpu_addr;

  assign ev_silent_upg = hit_done && cpu_we && (c_st == LN_E);
  assign xfer_end      = (ph == PH_XFER) && bus_done;
  assign fill_end      = xfer_end && (cur_cmd == BC_RD || cur_cmd == BC_RDX);
  assign loc_we        = ev_silent_upg || xfer_end;

  always_comb begin
    if (ev_silent_upg) loc_st = LN_M;
    else begin
      case (cur_cmd)
        BC_WB:   loc_st = LN_I;
        BC_UPG:  loc_st = LN_M;
        default: loc_st = fill_state(cur_cmd == BC_RDX, bus_shared_in);
      endcase
    end
  end

  assign s_hit          = snp_valid && (s_st != LN_I) && (d_tag == s_tag);
  assign snp_shared_out = s_hit;
  assign snp_wb_req     = s_hit && (s_st == LN_M) &&
                          (snp_cmd == BC_RD || snp_cmd == BC_RDX);
  assign snp_upd        = s_hit && (snp_cmd == BC_RD || snp_cmd == BC_RDX ||
                                    snp_cmd == BC_UPG);
  assign snp_st_new     = snoop_next(s_st, snp_cmd);

  coh_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag_cpu (
    .clk(clk), .rst_n(rst_n), .wr_en(fill_end), .wr_idx(c_idx), .wr_tag(c_tag),
    .rd_idx(c_idx), .rd_tag(p_tag));

  coh_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag_dup (
    .clk(clk), .rst_n(rst_n), .wr_en(fill_end), .wr_idx(c_idx), .wr_tag(c_tag),
    .rd_idx(s_idx), .rd_tag(d_tag));

  coh_state_array #(.IDX_W(IDX_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .loc_we(loc_we), .loc_idx(c_idx), .loc_st(loc_st),
    .snp_we(snp_upd), .snp_idx(s_idx), .snp_st(snp_st_new),
    .rd_idx_a(c_idx), .rd_st_a(c_st_raw),
    .rd_idx_b(s_idx), .rd_st_b(s_st_raw));
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic [2:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_done,
  input logic              snp_valid,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              snp_shared_out,
  input logic              snp_wb_req,
  input logic              ev_silent_upg
);
  assert_cmd_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_cmd >= 3'd1 && bus_cmd <= 3'd4));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  assert_cpu_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> !cpu_ready);

  assert_wb_has_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    snp_wb_req |-> snp_shared_out);

  assert_silent_upgrade_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_silent_upg |=> !bus_req);

  assert_snoop_blocks_hit_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && cpu_req && snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]) |-> !cpu_ready);
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
  .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_done(bus_done), .snp_valid(snp_valid), .snp_addr(snp_addr),
  .snp_shared_out(snp_shared_out), .snp_wb_req(snp_wb_req),
  .ev_silent_upg(ev_silent_upg));

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int NL     = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0, cpu_ready;
  logic [ADDR_W-1:0] cpu_addr = '0, bus_addr, snp_addr = '0;
  logic bus_req, bus_gnt = 0, bus_done = 0, bus_shared_in = 0;
  logic [2:0] bus_cmd, snp_cmd = '0;
  logic snp_valid = 0, snp_shared_out, snp_wb_req;

  int total = 0, bad = 0;
  int ms [NL];   // bench model: 0 I, 1 S, 2 E, 3 M
  int mt [NL];

  always #10 clk = ~clk;  // 50 MHz

  mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_done(bus_done), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared_out(snp_shared_out), .snp_wb_req(snp_wb_req));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cpu_op(input bit we, input int tag, input int idx, input bit sh);
    int exp_n, seen, ec [2], ea [2], addr;
    string er [2], fin;
    bit hit, got;
    addr = tag * NL + idx;
    exp_n = 0;
    hit = (ms[idx] != 0) && (mt[idx] == tag);
    if (hit && (!we || ms[idx] >= 2)) begin
      fin = we ? "R5" : "R6";
      if (we) ms[idx] = 3;
    end else if (hit) begin
      fin = "R4"; ec[0] = 3; ea[0] = addr; er[0] = "R4"; exp_n = 1; ms[idx] = 3;
    end else begin
      fin = "R11";
      if (ms[idx] == 3) begin
        ec[0] = 4; ea[0] = mt[idx] * NL + idx; er[0] = "R10"; exp_n = 1;
      end
      ec[exp_n] = we ? 2 : 1; ea[exp_n] = addr; er[exp_n] = we ? "R3" : "R2";
      exp_n++;
      ms[idx] = we ? 3 : (sh ? 1 : 2);
      mt[idx] = tag;
    end
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = ADDR_W'(addr);
    seen = 0; got = 0;
    for (int g = 0; g < 40; g++) begin
      #1;
      if (cpu_ready) begin got = 1; break; end
      if (bus_req) begin
        if (seen < exp_n)
          chk(bus_cmd == 3'(ec[seen]) && bus_addr == ADDR_W'(ea[seen]), er[seen],
              int'(bus_cmd) * 1000 + int'(bus_addr), ec[seen] * 1000 + ea[seen]);
        else
          chk(0, fin, int'(bus_cmd), 0);
        seen++;
        bus_gnt = 1;
        @(negedge clk);
        bus_gnt = 0; bus_done = 1; bus_shared_in = sh;
        #1 chk(!cpu_ready, "R11", int'(cpu_ready), 0);
        @(negedge clk);
        bus_done = 0; bus_shared_in = 0;
      end else begin
        @(negedge clk);
      end
    end
    chk(got && seen == exp_n, fin, seen, exp_n);
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
  endtask

  task automatic snoop(input int cmd, input int tag, input int idx);
    bit hit, ewb;
    string rw;
    hit = (ms[idx] != 0) && (mt[idx] == tag);
    ewb = hit && ms[idx] == 3 && (cmd == 1 || cmd == 2);
    rw = (cmd == 1) ? "R7" : ((cmd == 4) ? "R9" : "R8");
    @(negedge clk);
    snp_valid = 1; snp_cmd = 3'(cmd); snp_addr = ADDR_W'(tag * NL + idx);
    #1;
    chk(snp_shared_out == hit, "R9", int'(snp_shared_out), int'(hit));
    chk(snp_wb_req == ewb, rw, int'(snp_wb_req), int'(ewb));
    if (hit) begin
      if (cmd == 1 && ms[idx] >= 2) ms[idx] = 1;
      else if (cmd == 2 || cmd == 3) ms[idx] = 0;
    end
    @(posedge clk); #1;
    snp_valid = 0; snp_cmd = 0;
  endtask

  initial begin
    #150000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin ms[i] = 0; mt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(!bus_req && !cpu_ready, "R1", int'(bus_req) + int'(cpu_ready), 0);
    for (int i = 0; i < NL; i++) snoop(4, 0, i);

    // directed corners
    cpu_op(0, 2, 2, 0);   // R2 fill Exclusive
    cpu_op(1, 2, 2, 0);   // R5 silent upgrade
    cpu_op(0, 2, 2, 0);   // R6 read hit on Modified
    cpu_op(1, 1, 2, 0);   // R10 dirty victim then R3
    snoop(1, 1, 2);       // R7 write-back, to Shared
    cpu_op(1, 1, 2, 0);   // R4 upgrade
    snoop(2, 1, 2);       // R8 invalidate with write-back
    cpu_op(0, 3, 3, 1);   // R2 fill Shared
    cpu_op(1, 3, 3, 0);   // R4
    snoop(3, 3, 3);       // R8 upgrade snoop invalidates

    // sweep of access and snoop patterns against the model
    for (int r = 0; r < 48; r++) begin
      int idx, tag;
      idx = r % NL;
      tag = (r * 7 + r / 4) % 4;
      cpu_op(r % 3 == 1, tag, idx, r % 5 == 0);
      if (r % 2 == 0) snoop(1 + (r / 2) % 4, (r % 3 == 0) ? tag : (tag ^ 1), (r + 1) % NL);
    end

    // R12 / R13: same-index snoop holds off a hit, other index does not
    cpu_op(0, 5, 0, 0);
    cpu_op(0, 6, 1, 1);
    @(negedge clk);
    cpu_req = 1; cpu_we = 0; cpu_addr = ADDR_W'(5 * NL + 0);
    snp_valid = 1; snp_cmd = 3'd4; snp_addr = ADDR_W'(9 * NL + 0);
    #1 chk(!cpu_ready, "R12", int'(cpu_ready), 0);
    @(posedge clk); #1;
    snp_valid = 0;
    #1 chk(cpu_ready, "R12", int'(cpu_ready), 1);
    @(posedge clk); #1;
    cpu_req = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = ADDR_W'(5 * NL + 0);
    snp_valid = 1; snp_cmd = 3'd4; snp_addr = ADDR_W'(6 * NL + 1);
    #1;
    chk(cpu_ready, "R13", int'(cpu_ready), 1);
    chk(snp_shared_out, "R13", int'(snp_shared_out), 1);
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0; snp_valid = 0;
    ms[0] = 3;
    snoop(1, 5, 0);   // R7: the E line became Modified silently

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule